// File: doc/BRIEF.md
# Three-State Phase-Frequency Detector

This block sits at the heart of a digital frequency synthesizer loop. It takes two strobes that are already divided down: one from the reference path and one from the feedback (VCO) path. It reports which strobe arrived first and by how many clock cycles. The loop-error result comes out as a single-ended three-state signal, given as a drive-enable and a drive level. A pad cell outside the block can then float the line, pull it high or pull it low. Both internal arrival flags are also brought out directly, as a double-ended pair of pulse outputs.

Each path has a rising-edge detector. That detector sets a sticky flag for its path: `up_q` for the reference path and `dn_q` for the feedback path. Once both flags would be set, both are cleared together. The error pulse therefore lasts exactly as many clock cycles as the gap between the two arrivals. When the reference arrives first, the pulse is high, which means feedback lags or is slow. When the feedback arrives first, the pulse is low, which means feedback leads or is fast. When both arrive on the same cycle, the line is never driven.

Top module: `pfd_top`

## Requirements
- R1: While `rst_n` is low, `err_oe`, `up_q` and `dn_q` are 0, and asserting `rst_n` low clears them without waiting for a clock edge.
- R2: If the reference edge is sampled k cycles before the feedback edge (k ≥ 1), then from the cycle after the reference edge, `err_oe`=1 and `err_lvl`=1 for exactly k cycles, with `up_q`=1 over the same cycles.
- R3: If the feedback edge is sampled k cycles before the reference edge (k ≥ 1), then `err_oe`=1 and `err_lvl`=0 for exactly k cycles, with `dn_q`=1 over the same cycles.
- R4: Edges on both paths in the same cycle leave `err_oe`, `up_q` and `dn_q` at 0.
- R5: `up_q` and `dn_q` are never 1 together. `err_oe` is 1 exactly when one of them is 1. While `err_oe` is 1, `err_lvl` equals `up_q`.
- R6: Only a 0-to-1 transition of a strobe counts as an arrival, so a strobe held high for many cycles counts once.
- R7: When the feedback strobe period is shorter than the reference period, only low pulses (`err_lvl`=0) are produced, and at least one is produced.
- R8: When the feedback strobe period is longer than the reference period, only high pulses (`err_lvl`=1) are produced, and at least one is produced.
- R9: A further arrival on a path whose flag is already set has no effect. The pulse width is still measured from the first arrival.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| ref_strb | input | 1 | Divided reference strobe |
| fb_strb | input | 1 | Divided feedback strobe |
| err_oe | output | 1 | Drive-enable of the single-ended error output (0 = high impedance) |
| err_lvl | output | 1 | Drive level of the error output while enabled (1 = high, 0 = low) |
| up_q | output | 1 | Double-ended output: reference arrived first, waiting for feedback |
| dn_q | output | 1 | Double-ended output: feedback arrived first, waiting for reference |

## Verification
The hardest case to reach from the ports is a second arrival on a path whose flag is already set. A related case is a strobe that stays high while the other path's edge clears the pair. Both rest on the relative timing of the two strobes, not on their values. Directed tasks therefore place each strobe edge on a chosen cycle: a second reference pulse inside an open window, and a reference held high through and past the feedback edge. Two free-running strobe trains with unequal periods are then swept, so that lead and lag build up over many cycles, and the sign of every pulse is checked.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Drive state of the single-ended error output
  typedef enum logic [1:0] {
    DRV_FLOAT = 2'b00,
    DRV_HIGH  = 2'b01,
    DRV_LOW   = 2'b10
  } drv_e;

  // Index of each strobe path
  localparam int unsigned PATH_REF = 0;
  localparam int unsigned PATH_FB  = 1;
  localparam int unsigned NPATH    = 2;

endpackage

// File: rtl/pfd_rst_sync.sv
module pfd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_n_sync = sh_q[LAST];

endmodule

// File: rtl/pfd_strobe_edge.sv
module pfd_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strb,
  output logic evt
);

  logic prev_q;
  logic prev_d;
  logic prev_en;

  // Capture only on change, so the enable is explicit
  always_comb begin
    prev_en = strb ^ prev_q;
    prev_d  = strb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else if (prev_en) begin
      prev_q <= prev_d;
    end
  end

  assign evt = strb & ~prev_q;

endmodule

// File: rtl/pfd_latch_pair.sv
module pfd_latch_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_evt,
  input  logic fb_evt,
  output logic up_q,
  output logic dn_q
);

  logic up_set;
  logic dn_set;
  logic both;
  logic up_d;
  logic dn_d;
  logic upd_en;

  always_comb begin
    up_set = up_q | ref_evt;
    dn_set = dn_q | fb_evt;
    both   = up_set & dn_set;
    up_d   = up_set & ~both;
    dn_d   = dn_set & ~both;
    upd_en = ref_evt | fb_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (upd_en) begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

endmodule

// File: rtl/pfd_drive.sv
module pfd_drive
  import pfd_pkg::*;
(
  input  logic up,
  input  logic dn,
  output logic oe,
  output logic lvl
);

  drv_e mode;

  always_comb begin
    unique case ({up, dn})
      2'b10:   mode = DRV_HIGH;
      2'b01:   mode = DRV_LOW;
      default: mode = DRV_FLOAT;
    endcase
  end

  always_comb begin
    oe  = (mode != DRV_FLOAT);
    lvl = (mode == DRV_HIGH);
  end

endmodule

// File: rtl/pfd_top.sv
module pfd_top
  import pfd_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_strb,
  input  logic fb_strb,
  output logic err_oe,
  output logic err_lvl,
  output logic up_q,
  output logic dn_q
);

  logic             rst_n_i;
  logic [NPATH-1:0] strb_vec;
  logic [NPATH-1:0] evt_vec;

  pfd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign strb_vec[PATH_REF] = ref_strb;
  assign strb_vec[PATH_FB]  = fb_strb;

  for (genvar gi = 0; gi < NPATH; gi++) begin : g_edge
    pfd_strobe_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n_i),
      .strb  (strb_vec[gi]),
      .evt   (evt_vec[gi])
    );
  end

  pfd_latch_pair u_pair (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .ref_evt (evt_vec[PATH_REF]),
    .fb_evt  (evt_vec[PATH_FB]),
    .up_q    (up_q),
    .dn_q    (dn_q)
  );

  pfd_drive u_drv (
    .up  (up_q),
    .dn  (dn_q),
    .oe  (err_oe),
    .lvl (err_lvl)
  );

endmodule

// File: rtl/pfd_chk.sv
module pfd_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_strb,
  input logic fb_strb,
  input logic err_oe,
  input logic err_lvl,
  input logic up_q,
  input logic dn_q
);

  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && dn_q));

  assert_lvl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_oe |-> (err_lvl == up_q));

  assert_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q || dn_q) |-> err_oe);

  assert_up_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !fb_strb) |=> up_q);

  assert_dn_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_q && !ref_strb) |=> dn_q);

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_q && !dn_q && !ref_strb && !fb_strb) |=> !err_oe);

endmodule

bind pfd_top pfd_chk u_chk (.*);

// File: tb/sim_pfd_top.sv
`timescale 1ns/1ps
module sim_pfd_top;

  logic clk;
  logic rst_n;
  logic ref_strb;
  logic fb_strb;
  logic err_oe;
  logic err_lvl;
  logic up_q;
  logic dn_q;

  int n_tests = 0;
  int n_fail  = 0;
  int hi_cnt;
  int lo_cnt;
  int bad_cnt;

  pfd_top u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_strb (ref_strb),
    .fb_strb  (fb_strb),
    .err_oe   (err_oe),
    .err_lvl  (err_lvl),
    .up_q     (up_q),
    .dn_q     (dn_q)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive both strobes for one cycle, then sample after the edge
  task automatic step(input bit r, input bit f);
    @(negedge clk);
    ref_strb = r;
    fb_strb  = f;
    @(posedge clk);
    #1;
    if (err_oe && err_lvl) hi_cnt++;
    if (err_oe && !err_lvl) lo_cnt++;
    // R5: double-ended outputs consistent with error output
    if ((up_q !== (err_oe && err_lvl)) || (dn_q !== (err_oe && !err_lvl)) || (up_q && dn_q))
      bad_cnt++;
  endtask

  task automatic clear_counts();
    hi_cnt = 0; lo_cnt = 0; bad_cnt = 0;
  endtask

  task automatic settle();
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
  endtask

  // One reference and one feedback edge at chosen cycles
  task automatic run_pair(input int dr, input int df, input string req);
    int last;
    int exp_hi;
    int exp_lo;
    last   = (dr > df ? dr : df) + 3;
    exp_hi = (df > dr) ? df - dr : 0;
    exp_lo = (dr > df) ? dr - df : 0;
    clear_counts();
    for (int c = 0; c <= last; c++) step(c == dr, c == df);
    check(hi_cnt == exp_hi, req, hi_cnt, exp_hi);
    check(lo_cnt == exp_lo, req, lo_cnt, exp_lo);
    check(bad_cnt == 0, "R5", bad_cnt, 0);
    settle();
  endtask

  // R6: reference held high across and past the feedback edge
  task automatic run_held();
    clear_counts();
    for (int c = 0; c < 5; c++) step(1'b1, c == 4);
    check(hi_cnt == 4, "R6 held ref width", hi_cnt, 4);
    clear_counts();
    for (int c = 0; c < 6; c++) step(1'b1, 1'b0);
    check(hi_cnt == 0 && lo_cnt == 0, "R6 no retrigger", hi_cnt + lo_cnt, 0);
    settle();
  endtask

  // R9: second reference pulse while the flag is already set
  task automatic run_double();
    clear_counts();
    for (int c = 0; c < 9; c++) step(c == 0 || c == 3, c == 6);
    check(hi_cnt == 6, "R9 width from first arrival", hi_cnt, 6);
    check(lo_cnt == 0, "R9 no low pulse", lo_cnt, 0);
    settle();
  endtask

  // Free-running strobe trains
  task automatic run_freq(input int pr, input int pf);
    clear_counts();
    for (int c = 0; c < 400; c++) step((c % pr) == 0, (c % pf) == 0);
    settle();
  endtask

  task automatic run_reset_mid();
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    check(up_q == 1'b1, "R2 pulse open before reset", up_q, 1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!err_oe && !up_q && !dn_q, "R1 async clear", {err_oe, up_q, dn_q}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!err_oe && !up_q && !dn_q, "R1 idle after release", {err_oe, up_q, dn_q}, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    ref_strb = 1'b0;
    fb_strb = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!err_oe && !up_q && !dn_q, "R1 reset state", {err_oe, up_q, dn_q}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    run_pair(0, 3, "R2 ref leads 3");
    run_pair(0, 1, "R2 ref leads 1");
    run_pair(1, 8, "R2 ref leads 7");
    run_pair(4, 0, "R3 fb leads 4");
    run_pair(2, 1, "R3 fb leads 1");
    run_pair(2, 2, "R4 coincident");
    run_held();
    run_double();

    run_freq(10, 10);
    check(hi_cnt == 0 && lo_cnt == 0, "R4 equal freq and phase", hi_cnt + lo_cnt, 0);
    run_freq(10, 8);
    check(hi_cnt == 0, "R7 fast fb no high", hi_cnt, 0);
    check(lo_cnt > 0, "R7 fast fb low seen", lo_cnt, 1);
    check(bad_cnt == 0, "R5 fast fb", bad_cnt, 0);
    run_freq(8, 11);
    check(lo_cnt == 0, "R8 slow fb no low", lo_cnt, 0);
    check(hi_cnt > 0, "R8 slow fb high seen", hi_cnt, 1);

    run_reset_mid();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule